// File: doc/BRIEF.md
# Deglitched Supply Fault Status Register

This block sits behind a bank of analog window comparators that watch several supply rails. Each rail has three raw fault inputs: undervoltage (UV), overvoltage (OV) and overvoltage protection (OVP). Every raw input passes through a two-flop synchronizer and then through a deglitch timer of its own. The timer length is a cycle-count parameter chosen separately for each rail and fault kind. A fault only counts once it has been present for the full window. It then sets a sticky status flag and raises a one-cycle new-fault pulse.

The host reads the flags as three status words: one UV word, one OV word and one OVP word, each with one bit per rail. A read strobe with a word select acts as the clearing read. A flag is cleared only if its synchronized fault level has already returned to good. A flag whose fault is still present survives the read. While a rail is ramping up, its flags are forced to zero and its timers are held idle. A global monitor enable also holds all timers idle, so no new flags can set while it is low.

Each deglitch timer is a three-state machine with a counter. The states are:
- DG_GOOD: the input is at its good level.
- DG_COUNT: a fault is being timed.
- DG_FAULT: the fault is qualified.

The transitions are:
- GOOD to COUNT: the first faulty sample arrives.
- COUNT to GOOD: a good sample arrives before the count completes (restart).
- COUNT to FAULT: the sample count reaches the window length.
- FAULT to GOOD: the fault is removed.
- Any state to GOOD: hold is active (rail ramping, or monitor disabled).

Top module: `vmon_fault_status`

## Requirements
- R1: After reset, every status bit and every new-fault pulse output is 0.
- R2: A raw fault seen on fewer than LEN consecutive rising edges never sets its flag. LEN is the window of that rail and kind, and must be at least 2. A raw fault first sampled at edge E0 and held for at least LEN edges sets the flag at edge E0+LEN+2: two synchronizer stages, then LEN counted samples.
- R3: Each rail and kind has its own window and flag. A fault on one channel changes no other status bit.
- R4: A clearing read of a word leaves a bit at 1 while that bit's synchronized fault is still present.
- R5: A clearing read clears a bit whose synchronized fault is absent. rd_sel selects the word: 0 is UV, 1 is OV, 2 is OVP, 3 is none. Bits in words that are not selected are unaffected.
- R6: While ramping[r] is 1, all three flags of rail r read 0 from the next edge on and cannot set. Its timers restart once ramping drops.
- R7: While mon_en is 0, no flag goes from 0 to 1. Flags already set keep their value.
- R8: A fault that qualifies at the same edge as a clearing read of its word sets its flag, and its pulse is still produced.
- R9: A new-fault pulse is high for exactly one cycle: the cycle in which its flag first reads 1. It occurs only on a 0-to-1 change of that flag.
- R10: One good sample during DG_COUNT restarts the count, so two faulty runs of LEN-1 samples each, separated by a single good sample, do not set the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mon_en | input | 1 | Monitoring enable; 0 holds every timer idle |
| cmp_uv | input | NUM_RAILS | Raw UV comparator outputs, 1 = fault |
| cmp_ov | input | NUM_RAILS | Raw OV comparator outputs, 1 = fault |
| cmp_ovp | input | NUM_RAILS | Raw OVP comparator outputs, 1 = fault |
| ramping | input | NUM_RAILS | Per-rail ramp-up in progress |
| rd_strobe | input | 1 | Clearing read of the selected word |
| rd_sel | input | 2 | Word select: 0 UV, 1 OV, 2 OVP, 3 none |
| stat_uv | output | NUM_RAILS | Sticky UV status word |
| stat_ov | output | NUM_RAILS | Sticky OV status word |
| stat_ovp | output | NUM_RAILS | Sticky OVP status word |
| new_uv | output | NUM_RAILS | One-cycle pulse on a new UV flag |
| new_ov | output | NUM_RAILS | One-cycle pulse on a new OV flag |
| new_ovp | output | NUM_RAILS | One-cycle pulse on a new OVP flag |

## Verification
The vector table drives raw fault bursts exactly one sample shorter than each window and exactly equal to it, on several rails and all three kinds. This separates a correct sample count from an off-by-one, and shows that each channel uses its own length and disturbs no neighbour. Directed runs then test the following:
- Reading during a persistent fault and reading after removal, which separates a level-qualified clear from a blind one.
- A read that coincides with qualification, which shows that the set takes priority.
- Ramping and a disabled monitor, which show that the hold forces flags low and that setting is blocked.
- Two short bursts split by one good sample, which shows that the counter restarts rather than accumulates.

// File: rtl/vmon_pkg.sv
package vmon_pkg;
    typedef enum logic [1:0] {
        DG_GOOD  = 2'd0,
        DG_COUNT = 2'd1,
        DG_FAULT = 2'd2
    } dg_state_t;

    typedef enum logic [1:0] {
        SEL_UV   = 2'd0,
        SEL_OV   = 2'd1,
        SEL_OVP  = 2'd2,
        SEL_NONE = 2'd3
    } word_sel_t;

    localparam int NUM_KINDS = 3;
endpackage

// File: rtl/vmon_sync.sv
module vmon_sync #(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_in,
    output logic [WIDTH-1:0] d_out
);
    logic [WIDTH-1:0] stage1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1 <= '0;
            d_out  <= '0;
        end else begin
            stage1 <= d_in;
            d_out  <= stage1;
        end
    end
endmodule

// File: rtl/vmon_deglitch.sv
module vmon_deglitch
    import vmon_pkg::*;
#(
    parameter int unsigned LEN = 4,
    localparam int CW = $clog2(LEN + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hold,
    input  logic fault_in,
    output logic qual
);
    dg_state_t       st, st_n;
    logic [CW-1:0]   cnt, cnt_n;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st  <= DG_GOOD;
            cnt <= '0;
        end else begin
            st  <= st_n;
            cnt <= cnt_n;
        end
    end

    // transitions
    always_comb begin
        st_n  = st;
        cnt_n = cnt;
        if (hold) begin
            st_n  = DG_GOOD;
            cnt_n = '0;
        end else begin
            unique case (st)
                DG_GOOD: begin
                    if (fault_in) begin
                        st_n  = DG_COUNT;
                        cnt_n = CW'(1);
                    end
                end
                DG_COUNT: begin
                    if (!fault_in) begin
                        st_n  = DG_GOOD;
                        cnt_n = '0;
                    end else if (cnt == CW'(LEN - 1)) begin
                        st_n  = DG_FAULT;
                        cnt_n = '0;
                    end else begin
                        cnt_n = cnt + CW'(1);
                    end
                end
                DG_FAULT: begin
                    if (!fault_in) st_n = DG_GOOD;
                end
                default: begin
                    st_n  = DG_GOOD;
                    cnt_n = '0;
                end
            endcase
        end
    end

    // outputs
    always_comb begin
        qual = (st == DG_FAULT);
    end

    // R10: a good sample while counting sends the timer back to idle
    assert_restart_on_good_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (st == DG_COUNT && !fault_in) |=> (st == DG_GOOD));

    // R2: qualification only follows a faulty sample with no hold
    assert_qual_after_fault_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(qual) |-> ($past(fault_in) && !$past(hold)));
endmodule

// File: rtl/vmon_flag.sv
module vmon_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic ramp,
    input  logic qual,
    input  logic level,
    input  logic clr_req,
    output logic flag,
    output logic evt
);
    logic set_now;
    logic flag_n;

    always_comb begin
        set_now = qual && !ramp;
        if (ramp)                     flag_n = 1'b0;
        else if (set_now)             flag_n = 1'b1;
        else if (clr_req && !level)   flag_n = 1'b0;
        else                          flag_n = flag;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag <= 1'b0;
            evt  <= 1'b0;
        end else begin
            flag <= flag_n;
            evt  <= set_now && !flag;
        end
    end

    // R6: ramping forces the flag low at the next edge
    assert_ramp_forces_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ramp |=> !flag);

    // R4: a present fault keeps a set flag through any read
    assert_keep_while_present_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && level && !ramp) |=> flag);

    // R9: pulse lasts one cycle and coincides with a set flag
    assert_pulse_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        evt |=> !evt);
    assert_pulse_with_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
        evt |-> (flag && !$past(flag)));
endmodule

// File: rtl/vmon_fault_status.sv
module vmon_fault_status
    import vmon_pkg::*;
#(
    parameter int NUM_RAILS = 4,
    parameter int unsigned DGL_UV  [NUM_RAILS] = '{12, 6, 6, 24},
    parameter int unsigned DGL_OV  [NUM_RAILS] = '{4, 6, 6, 3},
    parameter int unsigned DGL_OVP [NUM_RAILS] = '{5, 5, 5, 5}
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 mon_en,
    input  logic [NUM_RAILS-1:0] cmp_uv,
    input  logic [NUM_RAILS-1:0] cmp_ov,
    input  logic [NUM_RAILS-1:0] cmp_ovp,
    input  logic [NUM_RAILS-1:0] ramping,
    input  logic                 rd_strobe,
    input  logic [1:0]           rd_sel,
    output logic [NUM_RAILS-1:0] stat_uv,
    output logic [NUM_RAILS-1:0] stat_ov,
    output logic [NUM_RAILS-1:0] stat_ovp,
    output logic [NUM_RAILS-1:0] new_uv,
    output logic [NUM_RAILS-1:0] new_ov,
    output logic [NUM_RAILS-1:0] new_ovp
);
    localparam int NCH = NUM_KINDS * NUM_RAILS;

    logic [NUM_KINDS-1:0][NUM_RAILS-1:0] raw, lvl, flags, evts;
    logic [NUM_KINDS-1:0]                clr;

    assign raw = {cmp_ovp, cmp_ov, cmp_uv};

    vmon_sync #(.WIDTH(NCH)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  (raw),
        .d_out (lvl)
    );

    always_comb begin
        for (int k = 0; k < NUM_KINDS; k++) begin
            clr[k] = rd_strobe && (rd_sel == 2'(k));
        end
    end

    for (genvar k = 0; k < NUM_KINDS; k++) begin : g_kind
        for (genvar r = 0; r < NUM_RAILS; r++) begin : g_rail
            localparam int unsigned LEN = (k == 0) ? DGL_UV[r] :
                                          (k == 1) ? DGL_OV[r] : DGL_OVP[r];
            logic qual;

            vmon_deglitch #(.LEN(LEN)) u_dgl (
                .clk      (clk),
                .rst_n    (rst_n),
                .hold     (ramping[r] || !mon_en),
                .fault_in (lvl[k][r]),
                .qual     (qual)
            );

            vmon_flag u_flag (
                .clk     (clk),
                .rst_n   (rst_n),
                .ramp    (ramping[r]),
                .qual    (qual),
                .level   (lvl[k][r]),
                .clr_req (clr[k]),
                .flag    (flags[k][r]),
                .evt     (evts[k][r])
            );
        end
    end

    assign stat_uv  = flags[0];
    assign stat_ov  = flags[1];
    assign stat_ovp = flags[2];
    assign new_uv   = evts[0];
    assign new_ov   = evts[1];
    assign new_ovp  = evts[2];

    // R7: with monitoring off for two cycles, no flag rises
    assert_no_set_when_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!mon_en && !$past(mon_en)) |=> ((flags & ~$past(flags)) == '0));

    // R5: a word that is not selected is never cleared by a read
    assert_unselected_kept_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_strobe && rd_sel == 2'(SEL_NONE) && ramping == '0) |=> ((~flags & $past(flags)) == '0));
endmodule

// File: tb/vmon_fault_status_test.sv
module vmon_fault_status_test;
    localparam int NR = 4;
    localparam int unsigned L_UV  [NR] = '{12, 6, 6, 24};
    localparam int unsigned L_OV  [NR] = '{4, 6, 6, 3};
    localparam int unsigned L_OVP [NR] = '{5, 5, 5, 5};

    // {rail[15:12], kind[11:8], run length[7:0]}; kind 0 UV, 1 OV, 2 OVP
    localparam int NV = 10;
    localparam logic [15:0] VEC [NV] = '{
        {4'd0, 4'd0, 8'd11}, {4'd0, 4'd0, 8'd12},
        {4'd1, 4'd1, 8'd5},  {4'd1, 4'd1, 8'd6},
        {4'd2, 4'd2, 8'd4},  {4'd2, 4'd2, 8'd5},
        {4'd3, 4'd1, 8'd2},  {4'd3, 4'd1, 8'd3},
        {4'd3, 4'd0, 8'd23}, {4'd3, 4'd0, 8'd24}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mon_en = 1'b1;
    logic [NR-1:0] cmp_uv = '0, cmp_ov = '0, cmp_ovp = '0, ramping = '0;
    logic rd_strobe = 1'b0;
    logic [1:0] rd_sel = 2'd3;
    logic [NR-1:0] stat_uv, stat_ov, stat_ovp, new_uv, new_ov, new_ovp;

    int errors = 0;
    int checks = 0;
    int evt_total = 0;

    always #10 clk = ~clk;

    vmon_fault_status #(.NUM_RAILS(NR), .DGL_UV(L_UV), .DGL_OV(L_OV), .DGL_OVP(L_OVP)) uut (
        .clk(clk), .rst_n(rst_n), .mon_en(mon_en),
        .cmp_uv(cmp_uv), .cmp_ov(cmp_ov), .cmp_ovp(cmp_ovp),
        .ramping(ramping), .rd_strobe(rd_strobe), .rd_sel(rd_sel),
        .stat_uv(stat_uv), .stat_ov(stat_ov), .stat_ovp(stat_ovp),
        .new_uv(new_uv), .new_ov(new_ov), .new_ovp(new_ovp)
    );

    always @(negedge clk) evt_total += $countones({new_uv, new_ov, new_ovp});

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic set_raw(input int kind, input int rail, input logic v);
        case (kind)
            0: cmp_uv[rail] = v;
            1: cmp_ov[rail] = v;
            default: cmp_ovp[rail] = v;
        endcase
    endtask

    function automatic logic [11:0] all_stat();
        return {stat_ovp, stat_ov, stat_uv};
    endfunction

    task automatic burst(input int kind, input int rail, input int run);
        @(negedge clk) set_raw(kind, rail, 1'b1);
        repeat (run) @(negedge clk);
        set_raw(kind, rail, 1'b0);
    endtask

    task automatic clear_read(input int kind);
        @(negedge clk);
        rd_strobe = 1'b1;
        rd_sel = 2'(kind);
        @(negedge clk);
        rd_strobe = 1'b0;
        rd_sel = 2'd3;
    endtask

    initial begin
        #(20 * 100000);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 status at reset", {20'd0, all_stat()}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 status after reset", {20'd0, all_stat()}, 32'd0);
        chk("R1 pulses after reset", {20'd0, new_ovp, new_ov, new_uv}, 32'd0);

        // table: runs one short of the window and exactly the window
        for (int i = 0; i < NV; i++) begin
            int rail, kind, run, len, ev0;
            logic exp;
            logic [11:0] expw;
            rail = int'(VEC[i][15:12]);
            kind = int'(VEC[i][11:8]);
            run  = int'(VEC[i][7:0]);
            len  = (kind == 0) ? int'(L_UV[rail]) : (kind == 1) ? int'(L_OV[rail]) : int'(L_OVP[rail]);
            exp  = (run >= len);
            expw = '0;
            expw[kind*NR + rail] = exp;
            ev0 = evt_total;
            burst(kind, rail, run);
            repeat (40) @(negedge clk);
            chk("R2 R3 status word after burst", {20'd0, all_stat()}, {20'd0, expw});
            chk("R9 pulse count", evt_total - ev0, exp ? 1 : 0);
            clear_read(kind);
            chk("R5 cleared after fault gone", {20'd0, all_stat()}, 32'd0);
        end

        // R4 then R5: read while present, read after removal
        @(negedge clk) cmp_uv[0] = 1'b1;
        repeat (20) @(negedge clk);
        chk("R4 set by long fault", 32'(stat_uv[0]), 32'd1);
        clear_read(0);
        chk("R4 read while present keeps bit", 32'(stat_uv[0]), 32'd1);
        cmp_uv[0] = 1'b0;
        repeat (3) @(negedge clk);
        clear_read(1);
        chk("R5 other word read leaves UV bit", 32'(stat_uv[0]), 32'd1);
        clear_read(0);
        chk("R5 read after removal clears", 32'(stat_uv[0]), 32'd0);

        // R8: qualification at the same edge as a clearing read of OV
        @(negedge clk) cmp_ov[1] = 1'b1;
        repeat (8) @(negedge clk);
        rd_strobe = 1'b1;
        rd_sel = 2'd1;
        @(negedge clk);
        rd_strobe = 1'b0;
        rd_sel = 2'd3;
        chk("R8 flag set despite read", 32'(stat_ov[1]), 32'd1);
        chk("R9 pulse in first set cycle", 32'(new_ov[1]), 32'd1);
        @(negedge clk);
        chk("R9 pulse drops after one cycle", 32'(new_ov[1]), 32'd0);
        cmp_ov[1] = 1'b0;
        repeat (3) @(negedge clk);
        clear_read(1);
        chk("R5 OV cleared", 32'(stat_ov[1]), 32'd0);

        // R6: ramping blocks and forces zero
        @(negedge clk) begin ramping[2] = 1'b1; cmp_uv[2] = 1'b1; end
        repeat (20) @(negedge clk);
        chk("R6 no set while ramping", 32'(stat_uv[2]), 32'd0);
        ramping[2] = 1'b0;
        repeat (12) @(negedge clk);
        chk("R6 sets after ramp ends", 32'(stat_uv[2]), 32'd1);
        ramping[2] = 1'b1;
        @(negedge clk);
        chk("R6 forced to zero by ramp", 32'(stat_uv[2]), 32'd0);
        cmp_uv[2] = 1'b0;
        repeat (3) @(negedge clk);
        ramping[2] = 1'b0;

        // R7: monitor disabled
        @(negedge clk) cmp_ov[3] = 1'b1;
        repeat (10) @(negedge clk);
        chk("R7 set before disable", 32'(stat_ov[3]), 32'd1);
        mon_en = 1'b0;
        cmp_uv[1] = 1'b1;
        repeat (20) @(negedge clk);
        chk("R7 no new flag when disabled", 32'(stat_uv[1]), 32'd0);
        chk("R7 existing flag held", 32'(stat_ov[3]), 32'd1);
        cmp_uv[1] = 1'b0;
        cmp_ov[3] = 1'b0;
        mon_en = 1'b1;
        repeat (3) @(negedge clk);
        clear_read(1);

        // R10: two runs of LEN-1 split by one good sample
        @(negedge clk) cmp_ov[2] = 1'b1;
        repeat (5) @(negedge clk);
        cmp_ov[2] = 1'b0;
        @(negedge clk) cmp_ov[2] = 1'b1;
        repeat (5) @(negedge clk);
        cmp_ov[2] = 1'b0;
        repeat (12) @(negedge clk);
        chk("R10 count restarts on good sample", {20'd0, all_stat()}, 32'd0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule